// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software programs it through a small register port. A vector-table entry holds the interrupt vector, a mask bit and a mode bit. A divide register selects the prescale ratio. Writing the initial-count register starts a countdown, and reading the current-count register shows the progress of the active period. A power-of-two prescaler turns core clocks into timer ticks. One period lasts the initial count plus one ticks.

When a period ends and the entry is unmasked, the block raises `irq_valid` for exactly one clock and presents the vector beside it. In one-shot mode the timer then stops. In periodic mode it reloads and runs again. A zero initial count keeps the timer idle. The interrupt output is a plain pulse with no back-pressure: whatever consumes it must take it in the cycle it is shown.

Top module: `loc_irq_timer`

## Requirements
- R1: Ticks are core clocks since the load, shifted right by a shift amount. The 3-bit divide code is {wr_data[3], wr_data[1:0]} of a divide write. Code 3'b111 gives shift 0, and codes 0 to 6 give shift code+1. After reset the shift is 0.
- R2: In one-shot mode (entry bit 17 = 0) a load of N != 0 produces a single interrupt exactly (N+1)<<shift clocks after the clock edge that took the load write, and nothing afterwards.
- R3: In periodic mode (entry bit 17 = 1) a load of N != 0 produces interrupts at every whole multiple of (N+1)<<shift clocks after the load edge.
- R4: An initial count of zero, in either mode, schedules no interrupt. Writing zero to a running timer stops it.
- R5: While the mask bit (entry bit 16) is set, no interrupt is raised.
- R6: Each interrupt is a one-clock pulse on irq_valid, with irq_vector equal to entry bits [7:0].
- R7: Reading the current count (select 3) returns N minus the ticks elapsed in the current period. It returns 0 when the timer is idle, including after a one-shot expiry.
- R8: A change of the mode bit takes effect from the next period boundary. The expiry that ends the current period still follows the mode that was in force when that period began.
- R9: After reset the entry reads 32'h0001_0000 (masked, one-shot, vector 0), the divide register and the current count read 0, and irq_valid is low.
- R10: Writing the initial count while the timer runs discards the old period and restarts the prescaler and the count from the new load edge.
- R11: Register selects are 0 for the entry (bits 17, 16 and 7:0 kept, others read 0), 1 for divide (bits 3, 1 and 0 kept), 2 for initial count (write-only, reads 0) and 3 for current count (read-only, writes ignored).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per asserted clock |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Combinational read data for rd_sel |
| irq_valid | output | 1 | One-clock interrupt request |
| irq_vector | output | 8 | Vector presented with irq_valid |

## Verification
An interrupt for a load taken at edge c0 is due in the cycle after edge c0+k·(N+1)·2^shift. The current count after edge c0+j reflects floor(j/2^shift) elapsed ticks. Register reads are combinational and are due in the same cycle. The driver records the edge at which each load write was taken and queues the expected edge numbers and vectors from these formulas. A monitor samples at the falling clock and pops the queue on every irq_valid, so an early, late, extra or missing pulse fails. Count reads are made at falling clocks at computed edge offsets.

// File: rtl/loc_timer_pkg.sv
package loc_timer_pkg;
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_INIT  = 2'd2,
    SEL_CUR   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       periodic;
    logic       masked;
    logic [7:0] vector;
  } entry_t;

  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
    return (code == 3'b111) ? SHIFT_W'(0) : SHIFT_W'(code + 3'd1);
  endfunction
endpackage

// File: rtl/loc_timer_regs.sv
module loc_timer_regs
  import loc_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output entry_t             entry,
  output logic [2:0]         div_code,
  output logic [SHIFT_W-1:0] shift,
  output logic               load,
  output logic [CNT_W-1:0]   load_val
);
  logic [2:0] code_in;

  assign code_in  = {wr_data[3], wr_data[1:0]};
  assign load     = wr_en && (wr_sel == SEL_INIT);
  assign load_val = wr_data[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry    <= '{periodic: 1'b0, masked: 1'b1, vector: 8'd0};
      div_code <= 3'd0;
      shift    <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_ENTRY) begin
        entry <= '{periodic: wr_data[17], masked: wr_data[16], vector: wr_data[7:0]};
      end
      if (wr_sel == SEL_DIV) begin
        div_code <= code_in;
        shift    <= code_to_shift(code_in);
      end
    end
  end
endmodule

// File: rtl/loc_timer_prescale.sv
module loc_timer_prescale
  import loc_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] lim;

  always_comb begin
    span = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
    lim  = span[PRE_W-1:0];
  end

  assign tick = run && ((pre_q & lim) == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/loc_timer_count.sv
module loc_timer_count
  import loc_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  entry_t           entry,
  output logic             active,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_valid,
  output logic [7:0]       irq_vector
);
  logic [CNT_W-1:0] elapsed;
  logic             mode_act;
  logic             expire;

  assign expire    = active && tick && (elapsed == init_q);
  assign cur_count = active ? (init_q - elapsed) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q     <= '0;
      elapsed    <= '0;
      active     <= 1'b0;
      mode_act   <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= 8'd0;
    end else begin
      irq_valid <= 1'b0;
      if (load) begin
        init_q   <= load_val;
        elapsed  <= '0;
        active   <= (load_val != '0);
        mode_act <= entry.periodic;
      end else if (expire) begin
        irq_valid  <= !entry.masked;
        irq_vector <= entry.vector;
        mode_act   <= entry.periodic;
        if (mode_act) begin
          elapsed <= '0;
        end else begin
          active <= 1'b0;
        end
      end else if (active && tick) begin
        elapsed <= elapsed + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
  import loc_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        irq_valid,
  output logic [7:0]  irq_vector
);
  entry_t             entry;
  logic [2:0]         div_code;
  logic [SHIFT_W-1:0] shift;
  logic               load;
  logic [CNT_W-1:0]   load_val;
  logic               tick;
  logic               active;
  logic [CNT_W-1:0]   init_q;
  logic [CNT_W-1:0]   cur_count;

  loc_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .entry(entry), .div_code(div_code), .shift(shift), .load(load), .load_val(load_val)
  );

  loc_timer_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(load), .shift(shift), .tick(tick)
  );

  loc_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(load_val),
    .entry(entry), .active(active), .init_q(init_q), .cur_count(cur_count),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_ENTRY: rd_data = {14'd0, entry.periodic, entry.masked, 8'd0, entry.vector};
      SEL_DIV:   rd_data = {28'd0, div_code[2], 1'b0, div_code[1:0]};
      SEL_INIT:  rd_data = 32'd0;
      default:   rd_data = 32'(cur_count);
    endcase
  end
endmodule

// File: rtl/loc_irq_timer_chk.sv
module loc_irq_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             irq_valid,
  input logic [7:0]       irq_vector,
  input logic             ent_masked,
  input logic [7:0]       ent_vector,
  input logic             tick,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] cur_count
);
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == $past(ent_vector));

  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(ent_masked));

  p_load_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> !irq_valid);

  p_cur_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count <= init_q);

  p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0) |-> !irq_valid);

  p_tick_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(tick));
endmodule

bind loc_irq_timer loc_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .irq_valid(irq_valid), .irq_vector(irq_vector),
  .ent_masked(entry.masked), .ent_vector(entry.vector),
  .tick(tick), .init_q(init_q), .cur_count(cur_count)
);

// File: tb/loc_irq_timer_tb.sv
`timescale 1ns/1ps
module loc_irq_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int unsigned cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int unsigned cyc;
    logic [7:0]  vec;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  loc_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  // Monitor: every pulse must match the head of the expectation queue.
  always @(negedge clk) begin
    if (rst_n && irq_valid && !done) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected irq at edge %0d vector %0h, expected none", cyc, irq_vector);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.cyc != cyc || e.vec != irq_vector) begin
          errors++;
          $display("FAIL %s irq edge %0d vec %0h, expected edge %0d vec %0h",
                   e.tag, cyc, irq_vector, e.cyc, e.vec);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data, output int unsigned edge_no);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    edge_no = cyc;
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push(input int unsigned c, input logic [7:0] v, input string tag);
    exp_t e;
    e.cyc = c; e.vec = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_drained(input string tag);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s missing irq count %0d expected 0", tag, q.size());
      q.delete();
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned c0, c1, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd_check("R9 entry reset", 2'd0, 32'h0001_0000);
    rd_check("R9 divide reset", 2'd1, 32'd0);
    rd_check("R9 count reset", 2'd3, 32'd0);
    check("R9 irq low", {31'd0, irq_valid}, 32'd0);

    // R5 masked one-shot: no pulse, and R11 entry bits readback
    wr(2'd0, 32'hFFFC_FF40 | 32'h0001_0000, t);
    rd_check("R11 entry readback", 2'd0, 32'h0001_0040);
    wr(2'd2, 32'd3, c0);
    wait_until(c0 + 20);
    expect_drained("R5 masked");

    // R2 one-shot, shift 0, vector 31, R7 mid count and after expiry
    wr(2'd0, 32'h0000_0031, t);
    wr(2'd2, 32'd4, c0);
    push(c0 + 5, 8'h31, "R2 one-shot");
    wait_until(c0 + 2);
    rd_check("R7 count mid period", 2'd3, 32'd2);
    wait_until(c0 + 30);
    expect_drained("R2 one-shot");
    rd_check("R7 count after one-shot", 2'd3, 32'd0);

    // R1 divide by 4 (code 001) and R11 divide readback
    wr(2'd1, 32'h0000_0001, t);
    rd_check("R11 divide readback", 2'd1, 32'h1);
    wr(2'd2, 32'd2, c0);
    push(c0 + 12, 8'h31, "R1 divide by 4");
    wait_until(c0 + 5);
    rd_check("R1 count at divide 4", 2'd3, 32'd1);
    wait_until(c0 + 40);
    expect_drained("R1 divide by 4");

    // R1 divide by 32 (code 100)
    wr(2'd1, 32'h0000_0008, t);
    wr(2'd2, 32'd1, c0);
    push(c0 + 64, 8'h31, "R1 divide by 32");
    wait_until(c0 + 100);
    expect_drained("R1 divide by 32");

    // R1 code 111 -> divide by 1; bit 2 not stored (R11)
    wr(2'd1, 32'h0000_000F, t);
    rd_check("R11 divide bit2 dropped", 2'd1, 32'hB);

    // R3 periodic, then R4 stop by writing zero
    wr(2'd0, 32'h0002_0055, t);
    wr(2'd2, 32'd3, c0);
    push(c0 + 4, 8'h55, "R3 periodic 1");
    push(c0 + 8, 8'h55, "R3 periodic 2");
    push(c0 + 12, 8'h55, "R3 periodic 3");
    wait_until(c0 + 13);
    wr(2'd2, 32'd0, t);
    rd_check("R4 count after stop", 2'd3, 32'd0);
    wait_until(c0 + 40);
    expect_drained("R3 periodic");

    // R4 periodic with zero count
    wr(2'd2, 32'd0, c0);
    wait_until(c0 + 20);
    expect_drained("R4 zero periodic");
    rd_check("R4 zero count idle", 2'd3, 32'd0);

    // R8 mode change at the period boundary
    wr(2'd0, 32'h0002_0066, t);
    wr(2'd2, 32'd5, c0);
    push(c0 + 6, 8'h66, "R8 old mode expiry");
    push(c0 + 12, 8'h66, "R8 new mode expiry");
    wait_until(c0 + 2);
    wr(2'd0, 32'h0000_0066, t);
    wait_until(c0 + 40);
    expect_drained("R8 mode change");

    // R10 reload restarts
    wr(2'd0, 32'h0000_0077, t);
    wr(2'd2, 32'd10, c0);
    wait_until(c0 + 4);
    wr(2'd2, 32'd2, c1);
    push(c1 + 3, 8'h77, "R10 reload");
    wait_until(c0 + 40);
    expect_drained("R10 reload");

    // R11 write to current count ignored, init reads 0
    wr(2'd2, 32'd20, c0);
    wait_until(c0 + 2);
    wr(2'd3, 32'd7, t);
    wait_until(c0 + 5);
    rd_check("R11 count write ignored", 2'd3, 32'd15);
    rd_check("R11 init reads zero", 2'd2, 32'd0);
    wr(2'd2, 32'd0, t);
    wait_until(c0 + 40);
    expect_drained("R4 stop one-shot");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule